// File: doc/BRIEF.md
# Sample FIFO Interrupt Controller

This block raises and tracks interrupt events for an audio sample FIFO. One side of the FIFO is filled by the processor and the other side is drained by the converter. The controller watches the access strobes together with the FIFO's full and empty flags and its free-entry count. It records three kinds of event: a data request, an overflow and an underrun. The FIFO storage itself sits outside this block.

Each event source has three controls. An enable bit sets whether the source drives the interrupt line. A sticky status bit records that the event happened, whether or not the source is enabled. A write-one-to-clear control resets the status bit. The single interrupt output is the OR of every status bit that has its enable set. A data request fires only on the accepted read that raises the free space to exactly one above the programmed threshold. This gives software one notice per refill window instead of a level that stays high.

All control and status pins are plain levels. The strobes carry no data and have no back-pressure, because the block only observes accesses that the FIFO has already taken or refused.

Top module: `sfi_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, en_q, status_q and irq are all zero.
- R2: A cycle with en_we high loads en_wdata into en_q, and the new value is visible after the next rising clock edge. Without en_we, en_q holds its value.
- R3: Bit 1 of status_q (overflow) is set after any cycle where wr_req is high while fifo_full is high.
- R4: Bit 2 of status_q (underrun) is set after any cycle where rd_req is high while fifo_empty is high.
- R5: Bit 0 of status_q (data request) is set after a cycle that has all of the following: an accepted read (rd_req high, fifo_empty low), no accepted write (wr_req low or fifo_full high), and free_cnt equal to threshold, so that the free space becomes threshold+1. Any other free_cnt value, or an accepted read paired with an accepted write, does not set it.
- R6: Status bits record events whatever en_q holds, and a set bit stays set until it is cleared.
- R7: A cycle with clr_we high clears each status bit whose clr_wdata bit is 1. Bits whose clr_wdata bit is 0 keep their value.
- R8: If a source's event and a clear of that same bit fall in the same cycle, the status bit ends up set.
- R9: irq is high exactly when some bit is set in both status_q and en_q. It follows those registers in the same cycle.
- R10: The clear port's readback clr_q is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Processor write attempt to the FIFO |
| rd_req | input | 1 | Converter read attempt from the FIFO |
| fifo_full | input | 1 | FIFO has no free entry |
| fifo_empty | input | 1 | FIFO holds no sample |
| free_cnt | input | $clog2(DEPTH+1) | Free entries before this cycle's accesses |
| threshold | input | THR_W | Data request threshold |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 3 | Enable value; bit0 request, bit1 overflow, bit2 underrun |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | 3 | Write-one-to-clear mask, same bit order |
| en_q | output | 3 | Current enables |
| status_q | output | 3 | Raw sticky status |
| clr_q | output | 3 | Clear register readback, always zero |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with DEPTH=8 and THR_W=4. A 4-bit threshold can then take values of DEPTH and above, where no read can ever satisfy the data request condition. These settings also let the bench drive free counts just below, at and just above the threshold. The small depth keeps the full range of free-entry values within a few directed steps. The bench also covers the cases where a clear meets an event in the same cycle and where reads and writes are accepted together.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_DREQ = 0;
  localparam int SRC_OVF  = 1;
  localparam int SRC_UDR  = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/sfi_event_detect.sv
module sfi_event_detect #(
  parameter int CNT_W = 5,
  parameter int THR_W = 5
) (
  input  logic                  wr_req,
  input  logic                  rd_req,
  input  logic                  fifo_full,
  input  logic                  fifo_empty,
  input  logic [CNT_W-1:0]      free_cnt,
  input  logic [THR_W-1:0]      threshold,
  output sfi_pkg::src_vec_t     events
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic             wr_take;
  logic             rd_take;
  logic [CMP_W-1:0] free_ext;
  logic [CMP_W-1:0] thr_ext;

  assign wr_take  = wr_req && !fifo_full;
  assign rd_take  = rd_req && !fifo_empty;
  assign free_ext = CMP_W'(free_cnt);
  assign thr_ext  = CMP_W'(threshold);

  always_comb begin
    events = '0;
    // a lone accepted read lifts the free space from threshold to threshold+1
    events[sfi_pkg::SRC_DREQ] = rd_take && !wr_take && (free_ext == thr_ext);
    events[sfi_pkg::SRC_OVF]  = wr_req && fifo_full;
    events[sfi_pkg::SRC_UDR]  = rd_req && fifo_empty;
  end
endmodule

// File: rtl/sfi_status_bit.sv
module sfi_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set_i | (q & ~clr_i);
  end
endmodule

// File: rtl/sfi_irq_merge.sv
module sfi_irq_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  output logic         irq
);
  assign irq = |(status & enable);
endmodule

// File: rtl/sfi_irq_ctrl.sv
module sfi_irq_ctrl #(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NS    = sfi_pkg::NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [CNT_W-1:0] free_cnt,
  input  logic [THR_W-1:0] threshold,
  input  logic             en_we,
  input  logic [NS-1:0]    en_wdata,
  input  logic             clr_we,
  input  logic [NS-1:0]    clr_wdata,
  output logic [NS-1:0]    en_q,
  output logic [NS-1:0]    status_q,
  output logic [NS-1:0]    clr_q,
  output logic             irq
);
  sfi_pkg::src_vec_t events;
  sfi_pkg::src_vec_t clr_mask;

  sfi_event_detect #(.CNT_W(CNT_W), .THR_W(THR_W)) u_det (
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .free_cnt   (free_cnt),
    .threshold  (threshold),
    .events     (events)
  );

  assign clr_mask = clr_we ? clr_wdata : '0;

  for (genvar i = 0; i < NS; i++) begin : g_src
    sfi_status_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (events[i]),
      .clr_i (clr_mask[i]),
      .q     (status_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  // write-only clear register reads as zero
  assign clr_q = '0;

  sfi_irq_merge #(.N(NS)) u_merge (
    .status (status_q),
    .enable (en_q),
    .irq    (irq)
  );
endmodule

// File: rtl/sfi_irq_ctrl_chk.sv
module sfi_irq_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_req,
  input logic             rd_req,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [CNT_W-1:0] free_cnt,
  input logic [THR_W-1:0] threshold,
  input logic             en_we,
  input logic [2:0]       en_wdata,
  input logic             clr_we,
  input logic [2:0]       clr_wdata,
  input logic [2:0]       en_q,
  input logic [2:0]       status_q,
  input logic             irq
);
  logic [2:0] clr_eff;
  logic       dreq_cond;
  assign clr_eff   = clr_we ? clr_wdata : 3'b000;
  assign dreq_cond = rd_req && !fifo_empty && !(wr_req && !fifo_full)
                     && (CMP_W'(free_cnt) == CMP_W'(threshold));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (en_q == 3'b000 && status_q == 3'b000 && !irq));

  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en_q == $past(en_wdata));

  a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && fifo_full) |=> status_q[1]);

  a_r4_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && fifo_empty) |=> status_q[2]);

  a_r5_data_request: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_cond |=> status_q[0]);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_eff)) & ~status_q) == 3'b000);

  a_r7_clear_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff[1] && !(wr_req && fifo_full)) |=> !status_q[1]);

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff[2] && rd_req && fifo_empty) |=> status_q[2]);

  a_r9_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((status_q & en_q) != 3'b000));
endmodule

bind sfi_irq_ctrl sfi_irq_ctrl_chk #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .free_cnt(free_cnt),
  .threshold(threshold), .en_we(en_we), .en_wdata(en_wdata),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .en_q(en_q),
  .status_q(status_q), .irq(irq)
);

// File: tb/sim_sfi_irq_ctrl.sv
module sim_sfi_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 0, rd_req = 0, fifo_full = 0, fifo_empty = 0;
  logic [3:0] free_cnt = 0, threshold = 0;
  logic       en_we = 0, clr_we = 0;
  logic [2:0] en_wdata = 0, clr_wdata = 0;
  logic [2:0] en_q, status_q, clr_q;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] en;
    logic [2:0] st;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [2:0] m_en = 0, m_st = 0;

  always #10 clk = ~clk;

  sfi_irq_ctrl #(.DEPTH(8), .THR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .free_cnt(free_cnt),
    .threshold(threshold), .en_we(en_we), .en_wdata(en_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata), .en_q(en_q),
    .status_q(status_q), .clr_q(clr_q), .irq(irq)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(input logic wr, input logic rd, input logic full,
                      input logic empty, input logic [3:0] fr, input logic [3:0] th,
                      input logic ewe, input logic [2:0] ed,
                      input logic cwe, input logic [2:0] cd, input string tag);
    logic [2:0] ev;
    logic       wt, rt;
    exp_t       e;
    @(negedge clk);
    wr_req = wr; rd_req = rd; fifo_full = full; fifo_empty = empty;
    free_cnt = fr; threshold = th; en_we = ewe; en_wdata = ed;
    clr_we = cwe; clr_wdata = cd;
    wt = wr && !full;
    rt = rd && !empty;
    ev[0] = rt && !wt && (fr == th);
    ev[1] = wr && full;
    ev[2] = rd && empty;
    m_st = ev | (m_st & ~(cwe ? cd : 3'b000));
    if (ewe) m_en = ed;
    e.en = m_en; e.st = m_st; e.irq = |(m_st & m_en); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 4'd4, 4'd3, 0, 3'b000, 0, 3'b000, tag);
  endtask

  // monitor: compare one item after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " status"}, {1'b0, status_q}, {1'b0, e.st});
      check({e.tag, " enable"}, {1'b0, en_q}, {1'b0, e.en});
      check({e.tag, " irq R9"}, {3'b0, irq}, {3'b0, e.irq});
      check("R10 clear readback", {1'b0, clr_q}, 4'b0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    check("R1 reset status", {1'b0, status_q}, 4'b0);
    check("R1 reset enable", {1'b0, en_q}, 4'b0);
    check("R1 reset irq", {3'b0, irq}, 4'b0);
    rst_n = 1'b1;
    idle("R1 first cycle");
    // R3 overflow with enables off also shows R6
    step(1, 0, 1, 0, 4'd0, 4'd3, 0, 3'b000, 0, 3'b000, "R3 overflow R6 masked");
    idle("R6 hold");
    step(0, 0, 0, 0, 4'd4, 4'd3, 0, 3'b000, 1, 3'b101, "R7 zero bit no effect");
    step(0, 0, 0, 0, 4'd4, 4'd3, 0, 3'b000, 1, 3'b010, "R7 clear overflow");
    // R4 underrun
    step(0, 1, 0, 1, 4'd8, 4'd3, 0, 3'b000, 0, 3'b000, "R4 underrun");
    step(0, 0, 0, 0, 4'd4, 4'd3, 1, 3'b100, 0, 3'b000, "R2 enable R9 irq");
    step(0, 0, 0, 0, 4'd4, 4'd3, 0, 3'b000, 1, 3'b100, "R7 clear underrun");
    // R5 data request window
    step(0, 1, 0, 0, 4'd2, 4'd3, 1, 3'b001, 0, 3'b000, "R5 below threshold");
    step(0, 1, 0, 0, 4'd4, 4'd3, 0, 3'b000, 0, 3'b000, "R5 above threshold");
    step(1, 1, 0, 0, 4'd3, 4'd3, 0, 3'b000, 0, 3'b000, "R5 paired write");
    step(0, 1, 0, 0, 4'd3, 4'd3, 0, 3'b000, 0, 3'b000, "R5 hit");
    step(1, 1, 1, 0, 4'd0, 4'd0, 0, 3'b000, 1, 3'b001, "R5 R8 read with full write");
    step(0, 0, 0, 0, 4'd4, 4'd3, 0, 3'b000, 1, 3'b011, "R7 clear two");
    step(0, 1, 0, 1, 4'd8, 4'd9, 0, 3'b000, 0, 3'b000, "R5 threshold beyond depth");
    step(0, 1, 0, 1, 4'd8, 4'd9, 0, 3'b000, 1, 3'b100, "R8 event beats clear");
    step(1, 0, 1, 0, 4'd0, 4'd3, 1, 3'b111, 1, 3'b111, "R8 overflow vs clear");
    step(0, 0, 0, 0, 4'd4, 4'd3, 1, 3'b000, 0, 3'b000, "R2 disable R9 irq low R6");
    step(0, 0, 0, 0, 4'd4, 4'd3, 0, 3'b000, 1, 3'b111, "R7 clear all");
    idle("final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule